// File: doc/BRIEF.md
# Calendar Clock Register Core

This block is a byte-addressed register core that keeps the time of day and the calendar. Seconds, minutes, hours, day of week, day of month, month and a two-digit year live in a ten-byte register file. Alarm bytes for seconds, minutes and hours sit between the time bytes. A one-per-second strobe from an external prescaler starts an update sequence. The sequence raises an update-busy status bit for a fixed number of clock cycles. It then advances the time with full carry through the calendar, and finally compares the result against the alarm bytes.

Software reaches every register through a simple address/data port. A control register chooses how values are stored: BCD or binary, and 12-hour or 24-hour. The same register holds a freeze bit, which lets software rewrite the time without an update racing the writes. Two sticky flags record an ended update and an alarm match. Each flag has its own enable. A read of the flag register returns the flags and clears them, and the interrupt request is the OR of every enabled flag.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset, the seconds, minutes, hours, year and alarm bytes (addresses 0-5, 9) read 0. Day of week, day of month and month (addresses 6, 7, 8) read 1. Address 10 reads 0x00, address 11 reads 0x02 and address 12 reads 0x00.
- R2: Addresses 0-9 and 11 read back what was last written. At address 10, bits 6:0 are writable and bit 7 is read-only. Address 12 ignores writes. Addresses 13-15 read 0.
- R3: While bit 7 of address 11 is 1, a tick strobe is ignored: the busy bit does not rise and the time does not change.
- R4: A tick accepted at a clock edge sets bit 7 of address 10 for exactly UIP_CYCLES (default 4) cycles. The time advances at the edge on which the bit falls. Ticks that arrive while the bit is set are ignored.
- R5: With bit 2 of address 11 at 1 (binary), seconds wrap from 59 to 0 into minutes, minutes from 59 to 0 into hours, and hours from 23 to 0 into the day counters. Day of week wraps from 7 to 1.
- R6: With bit 2 of address 11 at 0, every time byte holds two BCD digits and advances in BCD (0x09 to 0x10, 0x29 to 0x30).
- R7: With bit 1 of address 11 at 0 (12-hour), the hour byte holds 1-12, with bit 7 set for PM. 11 PM rolls to 12 AM and advances the day, 11 AM rolls to 12 PM, and 12 PM rolls to 1 PM.
- R8: Day of month wraps to 1 past the month's length: 30 days for months 4, 6, 9 and 11, 31 days for the other months, and 28 days for month 2 (29 when the year is divisible by 4). Month wraps from 12 to 1 into the year, and the year wraps from 99 to 0.
- R9: One cycle after each advance, bit 4 of address 12 (update ended) is set. Bit 5 (alarm) is also set when the seconds, minutes and hours bytes equal bytes 1, 3 and 5.
- R10: A read of address 12 returns the flags and clears them at that edge. A flag being set at the same edge stays set.
- R11: irq is high when bit 5 of address 12 and bit 5 of address 11 are both 1, or when bit 4 of address 12 and bit 4 of address 11 are both 1. It follows enable changes without any new update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickSec | input | 1 | One-per-second update strobe, one cycle wide |
| addr | input | ADDR_W | Register address |
| wrEn | input | 1 | Write strobe |
| wrData | input | 8 | Write data |
| rdEn | input | 1 | Read strobe; a read of address 12 clears the flags |
| rdData | output | 8 | Read data, combinational from addr while rdEn is high, else 0 |
| irq | output | 1 | Interrupt request |

## Verification
The two functions that can fall in the same cycle are the read-and-clear of the flag register and the end-of-update stage that sets the flags. The bench counts cycles from an accepted tick and issues the flag read exactly on the edge where the flags are being set. That read must still return the old value, 0x00. The next read must return the update-ended flag, which shows that the set won over the clear. A third read must return 0x00. The busy window is judged the same way, with a read in each cycle after the tick: four reads return 0x80 and the fifth returns 0x00.

// File: rtl/rtc_pkg.sv
`timescale 1ns/1ps
package rtc_pkg;
  localparam int TIME_REGS = 10;
  localparam int IDX_SEC  = 0;
  localparam int IDX_SECA = 1;
  localparam int IDX_MIN  = 2;
  localparam int IDX_MINA = 3;
  localparam int IDX_HOUR = 4;
  localparam int IDX_HRA  = 5;
  localparam int IDX_WDAY = 6;
  localparam int IDX_MDAY = 7;
  localparam int IDX_MON  = 8;
  localparam int IDX_YEAR = 9;
  localparam int ADDR_STAT = 10;
  localparam int ADDR_CTRL = 11;
  localparam int ADDR_FLAG = 12;
  localparam int BIT_FREEZE = 7;
  localparam int BIT_ALM    = 5;
  localparam int BIT_UPD    = 4;
  localparam int BIT_BIN    = 2;
  localparam int BIT_H24    = 1;
  localparam logic [7:0] CTRL_RESET = 8'h02;

  typedef struct packed {
    logic advance;
    logic finish;
  } rtcStrobe_t;

  function automatic logic [7:0] decodeVal(input logic [7:0] v, input logic bcd);
    return bcd ? (8'(v[7:4]) * 8'd10 + 8'(v[3:0])) : v;
  endfunction

  function automatic logic [7:0] encodeVal(input logic [7:0] n, input logic bcd);
    return bcd ? {4'(n / 8'd10), 4'(n % 8'd10)} : n;
  endfunction

  function automatic logic [7:0] monthDays(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'd2: return (yr[1:0] == 2'b00) ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11: return 8'd30;
      default: return 8'd31;
    endcase
  endfunction

  function automatic logic [7:0] resetByte(input int idx);
    return (idx == IDX_WDAY || idx == IDX_MDAY || idx == IDX_MON) ? 8'd1 : 8'd0;
  endfunction
endpackage

// File: rtl/rtc_update_ctrl.sv
`timescale 1ns/1ps
module rtc_update_ctrl
  import rtc_pkg::*;
#(
  parameter int UIP_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickSec,
  input  logic       freeze,
  output rtcStrobe_t strb,
  output logic       uip
);
  localparam int CNT_W = $clog2(UIP_CYCLES + 1);

  logic             busy;
  logic [CNT_W-1:0] cnt;
  logic             finishQ;
  logic             advanceNow;

  assign advanceNow = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      cnt     <= '0;
      finishQ <= 1'b0;
    end else begin
      finishQ <= advanceNow;
      if (!busy) begin
        if (tickSec && !freeze) begin
          busy <= 1'b1;
          cnt  <= CNT_W'(UIP_CYCLES - 1);
        end
      end else if (cnt == '0) begin
        busy <= 1'b0;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  assign strb.advance = advanceNow;
  assign strb.finish  = finishQ;
  assign uip          = busy;
endmodule

// File: rtl/rtc_datapath.sv
`timescale 1ns/1ps
module rtc_datapath
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  rtcStrobe_t        strb,
  input  logic              uip,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [7:0]        wrData,
  input  logic              rdEn,
  output logic [7:0]        rdData,
  output logic              irq,
  output logic              freeze
);
  localparam int IDX_W = $clog2(TIME_REGS);

  logic [7:0] tm [TIME_REGS];
  logic [6:0] statLow;
  logic [7:0] ctrlB;
  logic       flagAlm, flagUpd;

  logic       bcd, h24, timeSel, flagRead, alarmHit;
  logic [7:0] secB, minB, hrB, h12, wdayB, mdayB, monB, yrB;
  logic [7:0] nSec, nMin, nHr, nWday, nMday, nMon, nYr, hOut, hEnc;
  logic       cMin, cHr, cDay, cMon, cYr;

  assign bcd      = !ctrlB[BIT_BIN];
  assign h24      = ctrlB[BIT_H24];
  assign freeze   = ctrlB[BIT_FREEZE];
  assign timeSel  = (int'(addr) < TIME_REGS);
  assign flagRead = rdEn && (int'(addr) == ADDR_FLAG);
  assign alarmHit = (tm[IDX_SEC] == tm[IDX_SECA]) && (tm[IDX_MIN] == tm[IDX_MINA])
                 && (tm[IDX_HOUR] == tm[IDX_HRA]);

  // Next-second calendar arithmetic on binary values
  always_comb begin
    secB  = decodeVal(tm[IDX_SEC], bcd);
    minB  = decodeVal(tm[IDX_MIN], bcd);
    wdayB = decodeVal(tm[IDX_WDAY], bcd);
    mdayB = decodeVal(tm[IDX_MDAY], bcd);
    monB  = decodeVal(tm[IDX_MON], bcd);
    yrB   = decodeVal(tm[IDX_YEAR], bcd);
    h12   = decodeVal({1'b0, tm[IDX_HOUR][6:0]}, bcd);
    if (h24) hrB = decodeVal(tm[IDX_HOUR], bcd);
    else     hrB = ((h12 == 8'd12) ? 8'd0 : h12) + (tm[IDX_HOUR][7] ? 8'd12 : 8'd0);

    nSec = secB + 8'd1;  cMin = 1'b0;
    if (nSec >= 8'd60) begin nSec = 8'd0; cMin = 1'b1; end
    nMin = minB + 8'(cMin);  cHr = 1'b0;
    if (nMin >= 8'd60) begin nMin = 8'd0; cHr = 1'b1; end
    nHr = hrB + 8'(cHr);  cDay = 1'b0;
    if (nHr >= 8'd24) begin nHr = 8'd0; cDay = 1'b1; end
    nWday = wdayB + 8'(cDay);
    if (nWday > 8'd7) nWday = 8'd1;
    nMday = mdayB + 8'(cDay);  cMon = 1'b0;
    if (nMday > monthDays(monB, yrB)) begin nMday = 8'd1; cMon = 1'b1; end
    nMon = monB + 8'(cMon);  cYr = 1'b0;
    if (nMon > 8'd12) begin nMon = 8'd1; cYr = 1'b1; end
    nYr = yrB + 8'(cYr);
    if (nYr >= 8'd100) nYr = 8'd0;

    hEnc = (nHr >= 8'd12) ? nHr - 8'd12 : nHr;
    if (hEnc == 8'd0) hEnc = 8'd12;
    hEnc = encodeVal(hEnc, bcd);
    if (h24) hOut = encodeVal(nHr, bcd);
    else     hOut = {(nHr >= 8'd12), hEnc[6:0]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < TIME_REGS; i++) tm[i] <= resetByte(i);
      statLow <= '0;
      ctrlB   <= CTRL_RESET;
      flagAlm <= 1'b0;
      flagUpd <= 1'b0;
    end else begin
      if (strb.advance) begin
        tm[IDX_SEC]  <= encodeVal(nSec, bcd);
        tm[IDX_MIN]  <= encodeVal(nMin, bcd);
        tm[IDX_HOUR] <= hOut;
        tm[IDX_WDAY] <= encodeVal(nWday, bcd);
        tm[IDX_MDAY] <= encodeVal(nMday, bcd);
        tm[IDX_MON]  <= encodeVal(nMon, bcd);
        tm[IDX_YEAR] <= encodeVal(nYr, bcd);
      end else if (wrEn && timeSel) begin
        tm[addr[IDX_W-1:0]] <= wrData;
      end
      if (wrEn && int'(addr) == ADDR_STAT) statLow <= wrData[6:0];
      if (wrEn && int'(addr) == ADDR_CTRL) ctrlB   <= wrData;
      // Clear on read first; a set in the same cycle overrides it
      if (flagRead) begin
        flagAlm <= 1'b0;
        flagUpd <= 1'b0;
      end
      if (strb.finish) begin
        flagUpd <= 1'b1;
        if (alarmHit) flagAlm <= 1'b1;
      end
    end
  end

  always_comb begin
    rdData = '0;
    if (rdEn) begin
      if (timeSel)                         rdData = tm[addr[IDX_W-1:0]];
      else if (int'(addr) == ADDR_STAT)    rdData = {uip, statLow};
      else if (int'(addr) == ADDR_CTRL)    rdData = ctrlB;
      else if (int'(addr) == ADDR_FLAG) begin
        rdData[BIT_ALM] = flagAlm;
        rdData[BIT_UPD] = flagUpd;
      end
    end
  end

  assign irq = (flagAlm && ctrlB[BIT_ALM]) || (flagUpd && ctrlB[BIT_UPD]);
endmodule

// File: rtl/rtc_calendar_core.sv
`timescale 1ns/1ps
module rtc_calendar_core
  import rtc_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int UIP_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickSec,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [7:0]        wrData,
  input  logic              rdEn,
  output logic [7:0]        rdData,
  output logic              irq
);
  rtcStrobe_t strb;
  logic       uip;
  logic       freeze;

  rtc_update_ctrl #(.UIP_CYCLES(UIP_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .tickSec(tickSec), .freeze(freeze),
    .strb(strb), .uip(uip)
  );

  rtc_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .uip(uip), .addr(addr),
    .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn), .rdData(rdData),
    .irq(irq), .freeze(freeze)
  );
endmodule

// File: rtl/rtc_core_chk.sv
`timescale 1ns/1ps
module rtc_core_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              tickSec,
  input logic              wrEn,
  input logic              rdEn,
  input logic [ADDR_W-1:0] addr,
  input logic              irq,
  input logic              freeze,
  input logic              uip,
  input logic              advance,
  input logic              finish
);
  // R4
  tick_starts_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tickSec && !freeze && !uip) |=> uip);

  // R3
  frozen_tick_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tickSec && freeze && !uip) |=> !uip);

  // R4
  advance_in_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    advance |-> (uip && !$past(advance)));

  // R9
  finish_after_advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    advance |=> finish);

  // R10
  read_clears_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && int'(addr) == rtc_pkg::ADDR_FLAG && !finish) |=> !irq);

  // R11
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> ($past(finish) || $past(wrEn)));
endmodule

bind rtc_calendar_core rtc_core_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .tickSec(tickSec), .wrEn(wrEn), .rdEn(rdEn),
  .addr(addr), .irq(irq), .freeze(freeze), .uip(uip),
  .advance(strb.advance), .finish(strb.finish)
);

// File: tb/sim_rtc_calendar_core.sv
`timescale 1ns/1ps
module sim_rtc_calendar_core;
  logic       clk = 1'b0;
  logic       rstN;
  logic       tickSec;
  logic [3:0] addr;
  logic       wrEn;
  logic [7:0] wrData;
  logic       rdEn;
  logic [7:0] rdData;
  logic       irq;

  int nCmp = 0;
  int nBad = 0;
  bit finished = 0;

  typedef struct {
    logic [7:0] exp;
    logic [3:0] a;
    string      req;
    bit         check;
  } item_t;
  item_t sbq[$];

  always #2.5 clk = ~clk;

  rtc_calendar_core u0 (
    .clk(clk), .rstN(rstN), .tickSec(tickSec), .addr(addr), .wrEn(wrEn),
    .wrData(wrData), .rdEn(rdEn), .rdData(rdData), .irq(irq)
  );

  // Monitor: compares each read against the queued expectation
  always @(negedge clk) begin
    if (rstN && rdEn && sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      if (it.check) begin
        nCmp++;
        if (rdData !== it.exp) begin
          nBad++;
          $display("FAIL %s addr %0d: actual %h expected %h", it.req, it.a, rdData, it.exp);
        end
      end
    end
  end

  // Every task starts one time unit after a rising edge and ends likewise
  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    step();
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] e, input string req);
    item_t it;
    it.exp = e; it.a = a; it.req = req; it.check = 1'b1;
    sbq.push_back(it);
    addr = a; rdEn = 1'b1;
    step();
    rdEn = 1'b0;
  endtask

  task automatic drain(input logic [3:0] a);
    item_t it;
    it.exp = '0; it.a = a; it.req = "none"; it.check = 1'b0;
    sbq.push_back(it);
    addr = a; rdEn = 1'b1;
    step();
    rdEn = 1'b0;
  endtask

  task automatic tick();
    tickSec = 1'b1;
    step();
    tickSec = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic tickWait();
    tick();
    idle(6);
  endtask

  task automatic chkIrq(input logic e, input string req);
    @(negedge clk);
    nCmp++;
    if (irq !== e) begin
      nBad++;
      $display("FAIL %s irq: actual %b expected %b", req, irq, e);
    end
    step();
  endtask

  task automatic setTime(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
    wr(4'd4, h); wr(4'd2, m); wr(4'd0, s);
  endtask

  initial begin
    rstN = 1'b0; tickSec = 1'b0; addr = '0; wrEn = 1'b0; wrData = '0; rdEn = 1'b0;
    idle(3);
    rstN = 1'b0;
    step();
    rstN = 1'b1;

    // R1 reset values
    rd(4'd0, 8'h00, "R1"); rd(4'd4, 8'h00, "R1"); rd(4'd6, 8'h01, "R1");
    rd(4'd7, 8'h01, "R1"); rd(4'd8, 8'h01, "R1"); rd(4'd9, 8'h00, "R1");
    rd(4'd10, 8'h00, "R1"); rd(4'd11, 8'h02, "R1"); rd(4'd12, 8'h00, "R1");

    // R2 register access
    wr(4'd1, 8'h5A); rd(4'd1, 8'h5A, "R2");
    wr(4'd10, 8'hFF); rd(4'd10, 8'h7F, "R2"); wr(4'd10, 8'h00);
    wr(4'd12, 8'hFF); rd(4'd12, 8'h00, "R2");
    rd(4'd13, 8'h00, "R2"); wr(4'd1, 8'h00);

    // R5 / R8 binary full rollover, 23:59:59 Sat 31 Dec 99
    wr(4'd11, 8'h06);
    setTime(8'd23, 8'd59, 8'd59);
    wr(4'd6, 8'd7); wr(4'd7, 8'd31); wr(4'd8, 8'd12); wr(4'd9, 8'd99);
    tickWait();
    rd(4'd0, 8'd0, "R5"); rd(4'd2, 8'd0, "R5"); rd(4'd4, 8'd0, "R5");
    rd(4'd6, 8'd1, "R5"); rd(4'd7, 8'd1, "R8"); rd(4'd8, 8'd1, "R8");
    rd(4'd9, 8'd0, "R8");

    // R3 freeze ignores the tick
    wr(4'd11, 8'h86);
    tick();
    rd(4'd10, 8'h00, "R3");
    idle(6);
    rd(4'd0, 8'h00, "R3");
    wr(4'd11, 8'h06);

    // R4 busy window length, then advance
    tick();
    for (int k = 1; k <= 5; k++) rd(4'd10, (k < 5) ? 8'h80 : 8'h00, "R4");
    idle(2);
    rd(4'd0, 8'd1, "R4");

    // R8 leap year and month lengths
    setTime(8'd23, 8'd59, 8'd59); wr(4'd7, 8'd28); wr(4'd8, 8'd2); wr(4'd9, 8'd24);
    tickWait();
    rd(4'd7, 8'd29, "R8"); rd(4'd8, 8'd2, "R8");
    setTime(8'd23, 8'd59, 8'd59); wr(4'd7, 8'd28); wr(4'd8, 8'd2); wr(4'd9, 8'd23);
    tickWait();
    rd(4'd7, 8'd1, "R8"); rd(4'd8, 8'd3, "R8"); rd(4'd9, 8'd23, "R8");
    setTime(8'd23, 8'd59, 8'd59); wr(4'd7, 8'd30); wr(4'd8, 8'd4);
    tickWait();
    rd(4'd7, 8'd1, "R8"); rd(4'd8, 8'd5, "R8");

    // R6 BCD carries
    wr(4'd11, 8'h02);
    setTime(8'h09, 8'h59, 8'h59);
    tickWait();
    rd(4'd4, 8'h10, "R6"); rd(4'd2, 8'h00, "R6"); rd(4'd0, 8'h00, "R6");
    wr(4'd0, 8'h29);
    tickWait();
    rd(4'd0, 8'h30, "R6");

    // R7 12-hour mode
    wr(4'd11, 8'h00);
    setTime(8'h91, 8'h59, 8'h59); wr(4'd7, 8'h05); wr(4'd8, 8'h06); wr(4'd9, 8'h20);
    tickWait();
    rd(4'd4, 8'h12, "R7"); rd(4'd7, 8'h06, "R7");
    setTime(8'h11, 8'h59, 8'h59);
    tickWait();
    rd(4'd4, 8'h92, "R7");
    wr(4'd11, 8'h04);
    setTime(8'h8C, 8'd59, 8'd59);
    tickWait();
    rd(4'd4, 8'h81, "R7");

    // R9 / R11 alarm and update flags, binary 24h
    wr(4'd11, 8'h36);
    drain(4'd12);
    wr(4'd1, 8'd1); wr(4'd3, 8'd5); wr(4'd5, 8'd7);
    setTime(8'd7, 8'd5, 8'd0);
    tickWait();
    chkIrq(1'b1, "R11");
    wr(4'd11, 8'h06);
    chkIrq(1'b0, "R11");
    rd(4'd12, 8'h30, "R9");
    rd(4'd12, 8'h00, "R10");
    wr(4'd11, 8'h26);
    tickWait();
    chkIrq(1'b0, "R11");
    wr(4'd11, 8'h16);
    chkIrq(1'b1, "R11");
    rd(4'd12, 8'h10, "R9");
    chkIrq(1'b0, "R10");

    // R10 clear-on-read collides with the flag set
    tick();
    idle(4);
    rd(4'd12, 8'h00, "R10");
    rd(4'd12, 8'h10, "R10");
    rd(4'd12, 8'h00, "R10");

    idle(2);
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!finished) begin
      finished = 1;
      nCmp++;
      nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end
endmodule